// File: doc/BRIEF.md
# I2C Wiper Register Slave

This block is the serial control front end of a single-channel digital potentiometer with 128 taps. It watches the open-drain SCL and SDA lines of an I2C bus, brings both into the system clock domain, and decodes START, STOP, data bits and acknowledge clocks. When the master calls its 7-bit address, it accepts a command byte and one or more data bytes. Each fully received data byte, with its top bit removed, becomes the 7-bit wiper code.

Reads return the wiper code as a byte whose MSB is zero. A master may read straight after the address byte, without sending a command. It may also first send the address and command in write direction and then use a repeated START to read. The slave keeps sending the same byte for as long as the master acknowledges. The wiper code drives a tap-select output to the resistor array. A parameter chooses whether that output is one-hot across all taps or a plain binary code. A second parameter chooses which of the two fixed device addresses the slave answers to.

Top module: `i2c_wiper_slave`

## Requirements
- R1: After reset the wiper code is 0x40 (mid-scale), the tap output selects tap 64, and SDA is released (`sda_oe_n_o` = 1).
- R2: The slave acknowledges an address byte whose upper seven bits equal 0101110 (parameter `VARIANT_B` = 0) or 0111110 (`VARIANT_B` = 1); bit 0 of that byte is the direction, 0 for write and 1 for read. It changes its SDA drive only while SCL is low.
- R3: An address byte with any other upper seven bits is not acknowledged, and the slave leaves SDA released and the wiper unchanged until the next START or STOP.
- R4: In a write, the slave acknowledges command byte 0x00 and each following data byte. The wiper takes the new code on the third system clock after the falling SCL edge that ends that data byte's acknowledge clock.
- R5: Bit 7 of a written data byte is dropped: writing 0x80 reads back as 0x00, and writing 0xFF reads back as 0x7F.
- R6: A command byte other than 0x00 is not acknowledged, and data bytes that follow it up to the next START or STOP leave the wiper unchanged.
- R7: A read sent straight to the device address with direction 1 returns {0, wiper code}, MSB first. It is sent again after each master ACK, and after a master NACK the slave releases SDA.
- R8: A write phase carrying the address and command 0x00, followed by a repeated START and the address with direction 1, returns the wiper code.
- R9: A STOP or START in the middle of a data byte aborts the transfer without changing the wiper, and a transfer started after it works normally.
- R10: With `TAP_ONEHOT` = 1, the tap output has exactly one bit set, at the index equal to the wiper code, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_n_o | output | 1 | Open-drain enable for SDA, 0 pulls the line low |
| wiper_o | output | 7 | Current wiper code |
| tap_sel_o | output | 128 (one-hot) or 7 (binary) | Tap select to the resistor array |

## Verification
Every change on the bus reaches the byte engine three system clocks after it appears on a pin: two synchroniser flops and then the register that acts on the edge. A wiper update is therefore due on the third clock after the acknowledge clock's SCL falls. The bench's reference model arms a three-clock countdown at the moment it drops SCL, and it compares the wiper and tap outputs against the model on every falling clock edge. The master model moves SDA four clocks into each low phase and samples the line four clocks into each high phase. This gives the slave's three-clock delay room on both sides, so every ACK and every read bit is compared at a fixed, settled point.

// File: rtl/i2c_wiper_pkg.sv
package i2c_wiper_pkg;

    localparam int BYTE_W  = 8;
    localparam int WIPER_W = 7;
    localparam int CNT_W   = $clog2(BYTE_W + 1);

    localparam logic [WIPER_W-1:0] ADDR_VAR_A  = 7'b0101110;
    localparam logic [WIPER_W-1:0] ADDR_VAR_B  = 7'b0111110;
    localparam logic [BYTE_W-1:0]  CMD_WIPER   = 8'h00;
    localparam logic [WIPER_W-1:0] WIPER_RESET = 7'h40;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK,
        ST_SKIP
    } slv_state_e;

    typedef struct packed {
        slv_state_e          state;
        logic [BYTE_W-1:0]   shift;
        logic [CNT_W-1:0]    bits;
        logic                rw;
        logic                drive_low;
        logic [WIPER_W-1:0]  wiper;
    } core_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_regs_t;

    sync_regs_t sync_d, sync_q;
    logic       scl_s;

    assign scl_s = sync_q.scl_pipe[STAGES-1];
    assign sda_o = sync_q.sda_pipe[STAGES-1];

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_pipe = {sync_q.scl_pipe[STAGES-2:0], scl_i};
        sync_d.sda_pipe = {sync_q.sda_pipe[STAGES-2:0], sda_i};
        sync_d.scl_prev = scl_s;
        sync_d.sda_prev = sda_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    // Bus events, valid for one system clock.
    assign scl_rise_o = scl_s && !sync_q.scl_prev;
    assign scl_fall_o = !scl_s && sync_q.scl_prev;
    assign start_o    = scl_s && sync_q.scl_prev && sync_q.sda_prev && !sda_o;
    assign stop_o     = scl_s && sync_q.scl_prev && !sync_q.sda_prev && sda_o;

endmodule

// File: rtl/i2c_wiper_core.sv
module i2c_wiper_core
    import i2c_wiper_pkg::*;
#(
    parameter logic [WIPER_W-1:0] DEV_ADDR = ADDR_VAR_A
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sda_s,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_det,
    input  logic               stop_det,
    output logic               drive_low_o,
    output logic [WIPER_W-1:0] wiper_o
);

    localparam logic [CNT_W-1:0] BITS_FULL = CNT_W'(BYTE_W);

    core_regs_t core_d, core_q;

    always_comb begin
        core_d = core_q;
        if (start_det) begin
            core_d.state     = ST_ADDR;
            core_d.bits      = '0;
            core_d.drive_low = 1'b0;
        end else if (stop_det) begin
            core_d.state     = ST_IDLE;
            core_d.drive_low = 1'b0;
        end else begin
            unique case (core_q.state)
                ST_ADDR, ST_CMD, ST_DATA: begin
                    if (scl_rise && core_q.bits < BITS_FULL) begin
                        core_d.shift = {core_q.shift[BYTE_W-2:0], sda_s};
                        core_d.bits  = core_q.bits + 1'b1;
                    end else if (scl_fall && core_q.bits == BITS_FULL) begin
                        core_d.bits = '0;
                        if (core_q.state == ST_ADDR) begin
                            if (core_q.shift[BYTE_W-1:1] == DEV_ADDR) begin
                                core_d.rw        = core_q.shift[0];
                                core_d.drive_low = 1'b1;
                                core_d.state     = ST_ADDR_ACK;
                            end else begin
                                core_d.state = ST_SKIP;
                            end
                        end else if (core_q.state == ST_CMD) begin
                            if (core_q.shift == CMD_WIPER) begin
                                core_d.drive_low = 1'b1;
                                core_d.state     = ST_CMD_ACK;
                            end else begin
                                core_d.state = ST_SKIP;
                            end
                        end else begin
                            core_d.drive_low = 1'b1;
                            core_d.state     = ST_DATA_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        core_d.bits = '0;
                        if (core_q.rw) begin
                            core_d.shift     = {1'b0, core_q.wiper};
                            core_d.drive_low = ~core_d.shift[BYTE_W-1];
                            core_d.state     = ST_READ;
                        end else begin
                            core_d.drive_low = 1'b0;
                            core_d.state     = ST_CMD;
                        end
                    end
                end
                ST_CMD_ACK: begin
                    if (scl_fall) begin
                        core_d.drive_low = 1'b0;
                        core_d.state     = ST_DATA;
                    end
                end
                ST_DATA_ACK: begin
                    if (scl_fall) begin
                        core_d.drive_low = 1'b0;
                        core_d.wiper     = core_q.shift[WIPER_W-1:0];
                        core_d.state     = ST_DATA;
                    end
                end
                ST_READ: begin
                    if (scl_rise) begin
                        core_d.bits = core_q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (core_q.bits == BITS_FULL) begin
                            core_d.drive_low = 1'b0;
                            core_d.state     = ST_READ_ACK;
                        end else begin
                            core_d.shift     = {core_q.shift[BYTE_W-2:0], 1'b0};
                            core_d.drive_low = ~core_d.shift[BYTE_W-1];
                        end
                    end
                end
                ST_READ_ACK: begin
                    if (scl_rise && sda_s) begin
                        core_d.state = ST_SKIP;
                    end else if (scl_fall) begin
                        core_d.bits      = '0;
                        core_d.shift     = {1'b0, core_q.wiper};
                        core_d.drive_low = ~core_d.shift[BYTE_W-1];
                        core_d.state     = ST_READ;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q           <= '0;
            core_q.state     <= ST_IDLE;
            core_q.wiper     <= WIPER_RESET;
        end else begin
            core_q <= core_d;
        end
    end

    assign drive_low_o = core_q.drive_low;
    assign wiper_o     = core_q.wiper;

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int WIPER_W = 7,
    parameter bit ONE_HOT = 1'b1,
    parameter int TAP_W   = 128
) (
    input  logic [WIPER_W-1:0] wiper_i,
    output logic [TAP_W-1:0]   tap_o
);

    generate
        if (ONE_HOT) begin : g_onehot
            always_comb begin
                tap_o          = '0;
                tap_o[wiper_i] = 1'b1;
            end
        end else begin : g_binary
            assign tap_o = TAP_W'(wiper_i);
        end
    endgenerate

endmodule

// File: rtl/i2c_wiper_slave.sv
module i2c_wiper_slave
    import i2c_wiper_pkg::*;
#(
    parameter bit  VARIANT_B   = 1'b0,
    parameter bit  TAP_ONEHOT  = 1'b1,
    parameter int  SYNC_STAGES = 2,
    localparam int TAP_W       = TAP_ONEHOT ? (1 << WIPER_W) : WIPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_n_o,
    output logic [WIPER_W-1:0] wiper_o,
    output logic [TAP_W-1:0]   tap_sel_o
);

    localparam logic [WIPER_W-1:0] DEV_ADDR = VARIANT_B ? ADDR_VAR_B : ADDR_VAR_A;

    logic sda_s, scl_rise, scl_fall, start_det, stop_det, drive_low;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_wiper_core #(.DEV_ADDR(DEV_ADDR)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .drive_low_o (drive_low),
        .wiper_o     (wiper_o)
    );

    wiper_tap_decode #(.WIPER_W(WIPER_W), .ONE_HOT(TAP_ONEHOT), .TAP_W(TAP_W)) tap_i (
        .wiper_i (wiper_o),
        .tap_o   (tap_sel_o)
    );

    assign sda_oe_n_o = ~drive_low;

endmodule

// File: rtl/i2c_wiper_slave_chk.sv
module i2c_wiper_slave_chk #(
    parameter bit TAP_ONEHOT = 1'b1,
    parameter int WIPER_W    = 7,
    parameter int TAP_W      = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_i,
    input logic               sda_oe_n_o,
    input logic [WIPER_W-1:0] wiper_o,
    input logic [TAP_W-1:0]   tap_sel_o
);

    AST_RESET_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> wiper_o == 7'h40); // R1

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_n_o) |-> !scl_i); // R2

    AST_WIPER_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wiper_o) |-> !scl_i); // R4

    generate
        if (TAP_ONEHOT) begin : g_tap_chk
            AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
                $countones(tap_sel_o) == 1 && tap_sel_o[wiper_o]); // R10
        end
    endgenerate

endmodule

bind i2c_wiper_slave i2c_wiper_slave_chk #(
    .TAP_ONEHOT (TAP_ONEHOT),
    .WIPER_W    (i2c_wiper_pkg::WIPER_W),
    .TAP_W      (TAP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_n_o (sda_oe_n_o),
    .wiper_o    (wiper_o),
    .tap_sel_o  (tap_sel_o)
);

// File: tb/i2c_wiper_slave_tb_top.sv
module i2c_wiper_slave_tb_top;

    localparam logic [6:0] DEV   = 7'b0101110;
    localparam logic [6:0] OTHER = 7'b0111110;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         m_scl = 1'b1;
    logic         m_sda = 1'b1;
    logic         sda_line;
    logic         sda_oe_n;
    logic [6:0]   wiper;
    logic [127:0] tap_sel;

    int checks = 0;
    int fails  = 0;
    int exp_w  = 'h40;
    int pend   = 0;
    int upd_cnt = 0;
    bit arm    = 1'b0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = m_sda & sda_oe_n;

    i2c_wiper_slave dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe_n_o (sda_oe_n),
        .wiper_o    (wiper),
        .tap_sel_o  (tap_sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: pending wiper update lands three clocks after SCL falls.
    always @(posedge clk) begin
        if (upd_cnt > 0) begin
            if (upd_cnt == 1) exp_w <= pend;
            upd_cnt <= upd_cnt - 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(wiper) == exp_w, "R4 wiper per clock", int'(wiper), exp_w);
            check(tap_sel == (128'b1 << exp_w), "R10 tap per clock",
                  int'(tap_sel[exp_w]), 1);
        end
    end

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic r);
        m_sda = b;
        half();
        m_scl = 1'b1;
        half();
        r = sda_line;
        half();
        m_scl = 1'b0;
        if (arm) begin
            upd_cnt = 3;
            arm = 1'b0;
        end
        half();
    endtask

    task automatic start_c();
        m_sda = 1'b1;
        half();
        m_scl = 1'b1;
        half();
        m_sda = 1'b0;
        half();
        m_scl = 1'b0;
        half();
    endtask

    task automatic stop_c();
        m_sda = 1'b0;
        half();
        m_scl = 1'b1;
        half();
        m_sda = 1'b1;
        half();
    endtask

    task automatic send_byte(input logic [7:0] v, input bit upd, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) bit_cycle(v[i], r);
        if (upd) begin
            pend = int'(v[6:0]);
            arm  = 1'b1;
        end
        bit_cycle(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, r);
            v[i] = r;
        end
        bit_cycle(mack ? 1'b0 : 1'b1, r);
    endtask

    task automatic write_txn(input logic [6:0] a, input logic [7:0] cmd,
                             input logic [7:0] dat, input bit upd,
                             output bit k1, output bit k2, output bit k3);
        start_c();
        send_byte({a, 1'b0}, 1'b0, k1);
        send_byte(cmd, 1'b0, k2);
        send_byte(dat, upd, k3);
        stop_c();
    endtask

    task automatic short_read(output bit k, output logic [7:0] v);
        start_c();
        send_byte({DEV, 1'b1}, 1'b0, k);
        recv_byte(1'b0, v);
        stop_c();
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 200000);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        bit k1, k2, k3;
        logic [7:0] v, v2;
        logic r;

        repeat (3) @(negedge clk);
        check(int'(wiper) == 'h40, "R1 reset wiper", int'(wiper), 'h40);
        check(tap_sel == (128'b1 << 64), "R1 reset tap", int'(tap_sel[64]), 1);
        check(sda_oe_n == 1'b1, "R1 reset sda released", int'(sda_oe_n), 1);
        rst_n = 1'b1;
        half();

        // R2 / R4: basic write
        write_txn(DEV, 8'h00, 8'h25, 1'b1, k1, k2, k3);
        check(k1, "R2 address ack", int'(k1), 1);
        check(k2, "R4 command ack", int'(k2), 1);
        check(k3, "R4 data ack", int'(k3), 1);
        half();
        check(int'(wiper) == 'h25, "R4 wiper after write", int'(wiper), 'h25);

        // R7: short read, master ACKs once then NACKs
        start_c();
        send_byte({DEV, 1'b1}, 1'b0, k1);
        check(k1, "R7 read address ack", int'(k1), 1);
        recv_byte(1'b1, v);
        check(v == 8'h25, "R7 first read byte", int'(v), 'h25);
        recv_byte(1'b0, v2);
        check(v2 == 8'h25, "R7 repeated read byte", int'(v2), 'h25);
        half();
        check(sda_oe_n == 1'b1, "R7 release after nack", int'(sda_oe_n), 1);
        stop_c();

        // R5: MSB dropped
        write_txn(DEV, 8'h00, 8'h80, 1'b1, k1, k2, k3);
        short_read(k1, v);
        check(v == 8'h00, "R5 write 0x80 reads 0x00", int'(v), 'h00);
        write_txn(DEV, 8'h00, 8'hFF, 1'b1, k1, k2, k3);
        short_read(k1, v);
        check(v == 8'h7F, "R5 write 0xFF reads 0x7F", int'(v), 'h7F);

        // R3: foreign address ignored
        write_txn(OTHER, 8'h00, 8'h11, 1'b0, k1, k2, k3);
        check(!k1, "R3 foreign address nack", int'(k1), 0);
        check(!k2 && !k3, "R3 bus ignored", int'({k2, k3}), 0);
        check(int'(wiper) == 'h7F, "R3 wiper kept", int'(wiper), 'h7F);

        // R6: bad command nacked, data ignored
        write_txn(DEV, 8'h01, 8'h22, 1'b0, k1, k2, k3);
        check(k1, "R6 address ack", int'(k1), 1);
        check(!k2, "R6 bad command nack", int'(k2), 0);
        check(!k3, "R6 data ignored nack", int'(k3), 0);
        check(int'(wiper) == 'h7F, "R6 wiper kept", int'(wiper), 'h7F);

        // R8: combined read with repeated START
        write_txn(DEV, 8'h00, 8'h5A, 1'b1, k1, k2, k3);
        start_c();
        send_byte({DEV, 1'b0}, 1'b0, k1);
        send_byte(8'h00, 1'b0, k2);
        start_c();
        send_byte({DEV, 1'b1}, 1'b0, k3);
        check(k1 && k2 && k3, "R8 combined acks", int'({k1, k2, k3}), 7);
        recv_byte(1'b0, v);
        check(v == 8'h5A, "R8 combined read", int'(v), 'h5A);
        stop_c();

        // R9: STOP in mid data byte
        start_c();
        send_byte({DEV, 1'b0}, 1'b0, k1);
        send_byte(8'h00, 1'b0, k2);
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, r);
        stop_c();
        check(int'(wiper) == 'h5A, "R9 stop abort keeps wiper", int'(wiper), 'h5A);

        // R9: START in mid data byte, then a full write
        start_c();
        send_byte({DEV, 1'b0}, 1'b0, k1);
        send_byte(8'h00, 1'b0, k2);
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, r);
        start_c();
        check(int'(wiper) == 'h5A, "R9 start abort keeps wiper", int'(wiper), 'h5A);
        send_byte({DEV, 1'b0}, 1'b0, k1);
        send_byte(8'h00, 1'b0, k2);
        send_byte(8'h33, 1'b1, k3);
        stop_c();
        check(k1 && k2 && k3, "R9 write after abort acks", int'({k1, k2, k3}), 7);
        short_read(k1, v);
        check(v == 8'h33, "R9 write after abort", int'(v), 'h33);
        check(tap_sel == (128'b1 << 'h33), "R10 tap final", int'(tap_sel['h33]), 1);

        half();
        done = 1'b1;
        report();
        $finish;
    end

endmodule